// File: doc/BRIEF.md
# Round, Window Select and Saturate Output Stage

This block sits at the output of a filter datapath. It accepts a 20-bit two's complement word and delivers a 13-bit two's complement sample. The 20-bit word is first rounded at the position just below the chosen output window. One of four 13-bit windows is then taken from the rounded word. If the rounded value cannot be held in that window, the result saturates to the largest or smallest 13-bit value.

A 2-bit select input picks the window. Larger codes move the window toward the top of the word, which divides the result by a larger power of two. A round-enable input chooses between rounding and plain truncation. Each input word is marked by a valid strobe. The select and round controls are sampled together with the word, so a change to either takes effect on the next word. The output is registered and appears two clocks after its input, together with a matching valid.

Top module: `rsl_output_stage`

## Requirements
- R1: While `rst_n` is low, and in the first sample after it is released, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals the value `in_valid` had two rising clock edges earlier, and `out_data` belongs to that same input word.
- R3: The 13-bit window is taken from the rounded word as follows: `win_sel`=0 takes bits 16..4, 1 takes bits 17..5, 2 takes bits 18..6 and 3 takes bits 19..7. The lowest taken bit is L = 4 + `win_sel`.
- R4: When `round_en`=1, the value 2^(L-1) is added to the sign-extended input before the window is taken. This is round half up, toward positive infinity.
- R5: When `round_en`=0, nothing is added, so the result is the input shifted right arithmetically by L places, which rounds toward negative infinity.
- R6: If the rounded value divided by 2^L is greater than 4095, `out_data` is 0x0FFF.
- R7: If the rounded value divided by 2^L is less than -4096, `out_data` is 0x1000.
- R8: A rounding carry that pushes an in-range word past 4095 saturates to 0x0FFF and does not wrap to a negative value.
- R9: While no valid word reaches the output, `out_data` keeps its last value, whatever data is presented with `in_valid` low.
- R10: The sign bit of every valid output equals the sign of the rounded input word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a word to process |
| in_data | input | 20 | Input word, two's complement |
| win_sel | input | 2 | Window select code, sampled with the word |
| round_en | input | 1 | 1 rounds, 0 truncates; sampled with the word |
| out_valid | output | 1 | Marks `out_data` as a new result |
| out_data | output | 13 | Output sample, two's complement |

## Verification
Rounding and saturation can both act on the same word. The rounding carry can be the thing that pushes an in-range word out of range. The bench provokes this for every select code with a word whose window already holds 4095 and whose bit below the window is set. The rounded result must then read 0x0FFF and not wrap to a negative value. Truncated words just below the negative limit test the negative clamp. A behavioural model in the bench uses integer arithmetic, and its result is compared with the output on every clock during long random runs that change the select code, the round enable and the valid strobe.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
    // Default geometry of the output stage
    localparam int RSL_IN_W     = 20;
    localparam int RSL_OUT_W    = 13;
    localparam int RSL_NSEL     = 4;
    localparam int RSL_BASE_LSB = 4;
endpackage

// File: rtl/rsl_round.sv
// Stage 1: add half an output LSB (chosen window) and register the sum.
module rsl_round #(
    parameter int IN_W     = rsl_pkg::RSL_IN_W,
    parameter int NSEL     = rsl_pkg::RSL_NSEL,
    parameter int BASE_LSB = rsl_pkg::RSL_BASE_LSB,
    localparam int SUM_W   = IN_W + 1,
    localparam int SEL_W   = $clog2(NSEL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic [SEL_W-1:0] win_sel,
    input  logic             round_en,
    output logic             s1_valid,
    output logic [SUM_W-1:0] s1_sum,
    output logic [SEL_W-1:0] s1_sel
);
    logic [SUM_W-1:0] half;
    logic [SUM_W-1:0] sum_d;

    always_comb begin
        half = '0;
        for (int k = 0; k < NSEL; k++) begin
            if (round_en && (win_sel == SEL_W'(k))) begin
                half = SUM_W'(1) << (BASE_LSB + k - 1);
            end
        end
        sum_d = {in_data[IN_W-1], in_data} + half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sum   <= '0;
            s1_sel   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_sum <= sum_d;
                s1_sel <= win_sel;
            end
        end
    end

    // R2: stage-1 valid follows the input strobe by one edge
    p_stage_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    p_stage_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !s1_valid);
    // R5: with rounding off the sum is the bare sign-extended input
    p_trunc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !round_en) |=>
        (s1_sum == {$past(in_data[IN_W-1]), $past(in_data)}));
endmodule

// File: rtl/rsl_window_limit.sv
// Stage 2: pick the window, clamp on overflow, register the sample.
module rsl_window_limit #(
    parameter int IN_W     = rsl_pkg::RSL_IN_W,
    parameter int OUT_W    = rsl_pkg::RSL_OUT_W,
    parameter int NSEL     = rsl_pkg::RSL_NSEL,
    parameter int BASE_LSB = rsl_pkg::RSL_BASE_LSB,
    localparam int SUM_W   = IN_W + 1,
    localparam int SEL_W   = $clog2(NSEL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s1_valid,
    input  logic [SUM_W-1:0] s1_sum,
    input  logic [SEL_W-1:0] s1_sel,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam logic [OUT_W-1:0] POS_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] NEG_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    logic [OUT_W-1:0] win [NSEL];
    logic [NSEL-1:0]  fits;
    logic [OUT_W-1:0] res_d;

    for (genvar k = 0; k < NSEL; k++) begin : g_win
        localparam int LSB = BASE_LSB + k;
        localparam int MSB = LSB + OUT_W - 1;
        logic [SUM_W-MSB-1:0] upper;
        assign upper   = s1_sum[SUM_W-1:MSB];
        assign win[k]  = s1_sum[MSB:LSB];
        assign fits[k] = (&upper) | ~(|upper);
    end

    always_comb begin
        if (fits[s1_sel]) begin
            res_d = win[s1_sel];
        end else if (s1_sum[SUM_W-1]) begin
            res_d = NEG_MIN;
        end else begin
            res_d = POS_MAX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= res_d;
            end
        end
    end

    // R2: output valid follows stage-1 valid
    p_out_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    // R9: without a valid word the output holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> $stable(out_data));
    // R10: the output sign never differs from the rounded word's sign
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> (out_data[OUT_W-1] == $past(s1_sum[SUM_W-1])));
endmodule

// File: rtl/rsl_output_stage.sv
module rsl_output_stage #(
    parameter int IN_W     = rsl_pkg::RSL_IN_W,
    parameter int OUT_W    = rsl_pkg::RSL_OUT_W,
    parameter int NSEL     = rsl_pkg::RSL_NSEL,
    parameter int BASE_LSB = rsl_pkg::RSL_BASE_LSB,
    localparam int SUM_W   = IN_W + 1,
    localparam int SEL_W   = $clog2(NSEL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    input  logic [SEL_W-1:0] win_sel,
    input  logic             round_en,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    logic             s1_valid;
    logic [SUM_W-1:0] s1_sum;
    logic [SEL_W-1:0] s1_sel;

    rsl_round #(.IN_W(IN_W), .NSEL(NSEL), .BASE_LSB(BASE_LSB)) u_round (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .win_sel(win_sel), .round_en(round_en),
        .s1_valid(s1_valid), .s1_sum(s1_sum), .s1_sel(s1_sel)
    );

    rsl_window_limit #(.IN_W(IN_W), .OUT_W(OUT_W), .NSEL(NSEL),
                       .BASE_LSB(BASE_LSB)) u_limit (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_sum(s1_sum),
        .s1_sel(s1_sel), .out_valid(out_valid), .out_data(out_data)
    );

    // R1: reset clears the output
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));
endmodule

// File: tb/tb_rsl_output_stage.sv
`timescale 1ns/1ps
module tb_rsl_output_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [19:0] in_data = '0;
    logic [1:0]  win_sel = '0;
    logic        round_en = 1'b0;
    logic        out_valid;
    logic [12:0] out_data;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rsl_output_stage dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .win_sel(win_sel), .round_en(round_en),
        .out_valid(out_valid), .out_data(out_data)
    );

    // Reference pipeline: m1 = one edge old, m2 = expected at output
    bit          m1_v = 0, m2_v = 0;
    logic [12:0] m1_d = '0, m2_d = '0;
    bit          m1_neg = 0, m2_neg = 0;
    string       m1_tag = "R3", m2_tag = "R3";

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_word(input logic [19:0] d, input int sel, input bit rnd);
        int v, lsb, q, qt;
        lsb = 4 + sel;
        v = int'($signed(d));
        qt = v >>> lsb;
        if (rnd) v = v + (1 << (lsb - 1));
        q = v >>> lsb;
        m1_neg = (v < 0);
        if (q > 4095) begin
            m1_tag = (qt <= 4095) ? "R8" : "R6";
            q = 4095;
        end else if (q < -4096) begin
            m1_tag = "R7";
            q = -4096;
        end else begin
            m1_tag = rnd ? "R4" : "R5";
        end
        m1_d = q[12:0];
    endtask

    task automatic step(input bit v, input logic [19:0] d, input int sel, input bit rnd);
        in_valid = v; in_data = d; win_sel = sel[1:0]; round_en = rnd;
        @(posedge clk);
        m2_v = m1_v;
        if (m1_v) begin m2_d = m1_d; m2_tag = m1_tag; m2_neg = m1_neg; end
        m1_v = v;
        if (v) model_word(d, sel, rnd);
        @(negedge clk);
        chk(out_valid == m2_v, "R2", out_valid, m2_v);
        if (m2_v) begin
            chk(out_data == m2_d, m2_tag, out_data, m2_d);
            chk(out_data[12] == m2_neg, "R10", out_data[12], m2_neg);
        end else begin
            chk(out_data == m2_d, "R9", out_data, m2_d);
        end
    endtask

    initial begin
        #20_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        chk(out_data == 13'h0, "R1", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", out_valid, 0);

        // R3: window placement per select code, plain values
        for (int s = 0; s < 4; s++) begin
            step(1, 20'h00abc << s, s, 0);
            step(1, 20'h12345 >> 2, s, 1);
        end
        // R8: rounding carry into positive overflow, each code
        for (int s = 0; s < 4; s++) begin
            int lsb = 4 + s;
            step(1, 20'((4095 << lsb) + (1 << (lsb - 1))), s, 1);
            step(1, 20'((4095 << lsb) + (1 << (lsb - 1))), s, 0);
        end
        // R7/R6: negative and positive clamps
        for (int s = 0; s < 4; s++) begin
            int lsb = 4 + s;
            step(1, 20'((-4096 << lsb) - 1), s, 0);
            step(1, 20'((-4096 << lsb) - 1), s, 1);
            step(1, 20'h7ffff, s, 0);
            step(1, 20'h80000, s, 1);
        end
        // R9: invalid words carry other data, output must hold
        for (int i = 0; i < 6; i++) step(0, 20'($urandom), i % 4, i[0]);
        // Random mix
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) != 0, 20'($urandom), int'($urandom % 4), ($urandom % 2) == 1);
        for (int i = 0; i < 3; i++) step(0, '0, 0, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule